// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor core through its clock-control power states. A stop-clock request parks the core in a stopped state with its internal clocks gated. A halt indication parks it in a halted power-down state. From either of these, bus snoop or interrupt traffic moves the core briefly into a snoop-servicing state. From the stopped state, and only from there, a sleep request takes the core into a deep state in which every clock is off.

While the core is parked, the event pins (SMI, INIT and the two local interrupt lines) are captured in pending latches. Each pending event gives a single service pulse when the core next runs. The controller also watches for protocol misuse: a sleep request outside the stopped state, or any bus activity or input movement while asleep, sets a sticky violation flag. A system integrator drives the inputs from the chipset's power-management logic and uses the clock-enable outputs to gate the core's clock trees.

Top module: `lps_ctrl`

## Requirements
- R1: In the stopped (1), halted (2) and snoop (3) states, any cycle in which an event pin is high sets that pin's pending latch. No service pulse is produced while the core is in these states. Event bit positions are 0=SMI, 1=INIT, 2=LINT0 and 3=LINT1.
- R2: In the first cycle after the core enters Normal, `evt_svc` pulses exactly the set of pending events, once each, however many times each was asserted, and the latches clear. While the core stays in Normal, a rising edge on an event pin gives a one-cycle pulse on the following cycle.
- R3: From Normal, `stop_req` moves the state to stopped, taking priority over `halt_in`. Otherwise `halt_in` moves it to halted. In stopped, with `stop_req` low and neither a sleep request nor bus traffic present, the state returns to Normal.
- R4: In stopped or halted, `snoop_in` or `intr_txn` moves the state to snoop. The state leaves snoop on `snoop_done`, or one cycle after entry when the entry was caused by an interrupt transaction alone. It returns to whichever state it came from.
- R5: Sleep (4) is entered only from stopped, while `sleep_req` is high. A `sleep_req` in Normal, halted or snoop sets `viol_o` and does not enter Sleep.
- R6: `core_clk_en` is high only in Normal. `bus_clk_en` is low only in Sleep. `snoop_resp_en` is high only in snoop.
- R7: In Sleep, event pins are not latched. Bus traffic, or any change of `stop_req`, `halt_in`, `snoop_done` or an event pin, sets `viol_o`. Dropping `sleep_req` returns the state to stopped.
- R8: In halted, an event pin or a pending event returns the core to Normal, with its service pulse in the first Normal cycle.
- R9: The synchronous active-high reset puts the state in Normal and clears the pending latches and `viol_o`, including from Sleep. Outside reset, `viol_o` stays set once it is raised.
- R10: `state_o` uses the encoding Normal=0, stopped=1, halted=2, snoop=3, Sleep=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Sleep request |
| halt_in | input | 1 | Core has executed a halt |
| snoop_in | input | 1 | Snoop transaction on the bus |
| intr_txn | input | 1 | Interrupt transaction on the bus |
| snoop_done | input | 1 | Current snoop has been serviced |
| evt_in | input | NUM_EVT | Event pins (SMI, INIT, LINT0, LINT1) |
| state_o | output | 3 | Current power state |
| core_clk_en | output | 1 | Core internal clock enable |
| bus_clk_en | output | 1 | Bus interface clock enable |
| snoop_resp_en | output | 1 | Snoop response enable |
| evt_svc | output | NUM_EVT | One-cycle event service pulses |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
All outputs are registered or decoded from registered state. Each result is therefore due exactly one clock edge after the stimulus that causes it: the new state, the violation flag and the service pulse on entry to Normal all appear after the same edge. A service pulse for an edge seen in Normal also appears one edge later, and it lasts one cycle. The bench drives inputs one nanosecond after a rising edge and samples right after the next rising edge, so every check reads the response to the previous cycle's inputs. Every one of the sixteen event patterns is swept through the stopped path, and every nonzero pattern through the halted wake path, with the expected pulse being the pattern itself.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_NORMAL = 3'd0,
        ST_STOPG  = 3'd1,
        ST_AHALT  = 3'd2,
        ST_SNOOP  = 3'd3,
        ST_SLEEP  = 3'd4
    } lps_state_e;

    // FSM register image: current state, return target for the snoop
    // substate, and whether snoop entry was caused by interrupt traffic only.
    typedef struct packed {
        lps_state_e state;
        lps_state_e ret;
        logic       intonly;
    } lps_fsm_t;

endpackage

// File: rtl/lps_evt_bank.sv
module lps_evt_bank #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               stopped_q,   // current state is a latching state
    input  logic               stay_normal, // Normal now and next cycle
    input  logic               leave_normal,// Normal now, stopped next cycle
    input  logic               flush,       // entering Normal from a stopped state
    output logic [NUM_EVT-1:0] pend_o,
    output logic [NUM_EVT-1:0] svc_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] pend;
        logic [NUM_EVT-1:0] prev;
        logic [NUM_EVT-1:0] svc;
    } bank_t;

    bank_t b_d, b_q;
    logic [NUM_EVT-1:0] cap;
    logic [NUM_EVT-1:0] pend_nx;
    logic [NUM_EVT-1:0] svc_nx;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_evt
            assign cap[gi] = (stopped_q & evt_in[gi])
                           | (leave_normal & evt_in[gi] & ~b_q.prev[gi]);
            assign pend_nx[gi] = flush ? 1'b0 : (b_q.pend[gi] | cap[gi]);
            assign svc_nx[gi]  = flush ? (b_q.pend[gi] | cap[gi])
                                       : (stay_normal & evt_in[gi] & ~b_q.prev[gi]);

            // R1: a pending event stays pending until the core enters Normal
            assert_pend_hold_R1: assert property (@(posedge clk) disable iff (rst)
                (b_q.pend[gi] && !flush) |=> b_q.pend[gi]);
        end
    endgenerate

    always_comb begin
        b_d      = b_q;
        b_d.pend = pend_nx;
        b_d.prev = evt_in;
        b_d.svc  = svc_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign pend_o = b_q.pend;
    assign svc_o  = b_q.svc;

endmodule

// File: rtl/lps_viol_mon.sv
module lps_viol_mon #(
    parameter int WATCH_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_sleep,
    input  logic               bad_sleep_req,
    input  logic               bus_act,
    input  logic [WATCH_W-1:0] watch,
    output logic               viol_o
);

    typedef struct packed {
        logic [WATCH_W-1:0] prev;
        logic               viol;
    } mon_t;

    mon_t m_d, m_q;
    logic moved;

    assign moved = (watch != m_q.prev);

    always_comb begin
        m_d      = m_q;
        m_d.prev = watch;
        m_d.viol = m_q.viol | bad_sleep_req | (in_sleep & (bus_act | moved));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign viol_o = m_q.viol;

    // R9: the violation flag is sticky outside reset
    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        m_q.viol |=> m_q.viol);

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_req,
    input  logic               sleep_req,
    input  logic               halt_in,
    input  logic               snoop_in,
    input  logic               intr_txn,
    input  logic               snoop_done,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [STATE_W-1:0] state_o,
    output logic               core_clk_en,
    output logic               bus_clk_en,
    output logic               snoop_resp_en,
    output logic [NUM_EVT-1:0] evt_svc,
    output logic               viol_o
);

    localparam int WATCH_W = NUM_EVT + 3;

    lps_fsm_t f_d, f_q;
    logic               bad_sleep;
    logic               bus_act;
    logic               wake;
    logic [NUM_EVT-1:0] pend;
    logic               stopped_q, stopped_d;
    logic               stay_normal, leave_normal, flush;

    assign bus_act = snoop_in | intr_txn;
    assign wake    = |(pend | evt_in);

    always_comb begin
        f_d       = f_q;
        bad_sleep = 1'b0;
        unique case (f_q.state)
            ST_NORMAL: begin
                bad_sleep = sleep_req;
                if (stop_req)     f_d.state = ST_STOPG;
                else if (halt_in) f_d.state = ST_AHALT;
            end
            ST_STOPG: begin
                if (sleep_req) begin
                    f_d.state = ST_SLEEP;
                end else if (bus_act) begin
                    f_d.state   = ST_SNOOP;
                    f_d.ret     = ST_STOPG;
                    f_d.intonly = intr_txn & ~snoop_in;
                end else if (!stop_req) begin
                    f_d.state = ST_NORMAL;
                end
            end
            ST_AHALT: begin
                bad_sleep = sleep_req;
                if (bus_act) begin
                    f_d.state   = ST_SNOOP;
                    f_d.ret     = ST_AHALT;
                    f_d.intonly = intr_txn & ~snoop_in;
                end else if (wake) begin
                    f_d.state = ST_NORMAL;
                end
            end
            ST_SNOOP: begin
                bad_sleep = sleep_req;
                if (snoop_done || f_q.intonly) f_d.state = f_q.ret;
            end
            ST_SLEEP: begin
                if (!sleep_req) f_d.state = ST_STOPG;
            end
            default: f_d.state = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '{state: ST_NORMAL, ret: ST_STOPG, intonly: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign stopped_q = (f_q.state == ST_STOPG) || (f_q.state == ST_AHALT)
                    || (f_q.state == ST_SNOOP);
    assign stopped_d = (f_d.state == ST_STOPG) || (f_d.state == ST_AHALT)
                    || (f_d.state == ST_SNOOP);
    assign stay_normal  = (f_q.state == ST_NORMAL) && (f_d.state == ST_NORMAL);
    assign leave_normal = (f_q.state == ST_NORMAL) && stopped_d;
    assign flush        = stopped_q && (f_d.state == ST_NORMAL);

    lps_evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
        .clk          (clk),
        .rst          (rst),
        .evt_in       (evt_in),
        .stopped_q    (stopped_q),
        .stay_normal  (stay_normal),
        .leave_normal (leave_normal),
        .flush        (flush),
        .pend_o       (pend),
        .svc_o        (evt_svc)
    );

    lps_viol_mon #(.WATCH_W(WATCH_W)) u_viol (
        .clk           (clk),
        .rst           (rst),
        .in_sleep      (f_q.state == ST_SLEEP),
        .bad_sleep_req (bad_sleep),
        .bus_act       (bus_act),
        .watch         ({stop_req, halt_in, snoop_done, evt_in}),
        .viol_o        (viol_o)
    );

    assign state_o       = f_q.state;
    assign core_clk_en   = (f_q.state == ST_NORMAL);
    assign bus_clk_en    = (f_q.state != ST_SLEEP);
    assign snoop_resp_en = (f_q.state == ST_SNOOP);

    // R5: Sleep is reachable only from the stopped state
    assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (f_q.state != ST_STOPG && f_q.state != ST_SLEEP) |=> (f_q.state != ST_SLEEP));

    // R4: a finished snoop returns to the state it came from
    assert_snoop_return_R4: assert property (@(posedge clk) disable iff (rst)
        (f_q.state == ST_SNOOP && snoop_done) |=> (f_q.state == $past(f_q.ret)));

    // R2: service pulses only ever appear while running in Normal
    assert_svc_in_normal_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_svc) |-> (state_o == 3'd0));

endmodule

// File: tb/lps_ctrl_test.sv
`timescale 1ns/1ps
module lps_ctrl_test;

    logic       clk = 1'b0;
    logic       rst, stop_req, sleep_req, halt_in, snoop_in, intr_txn, snoop_done;
    logic [3:0] evt_in;
    logic [2:0] state_o;
    logic       core_clk_en, bus_clk_en, snoop_resp_en, viol_o;
    logic [3:0] evt_svc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lps_ctrl #(.NUM_EVT(4)) uut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .sleep_req(sleep_req),
        .halt_in(halt_in), .snoop_in(snoop_in), .intr_txn(intr_txn),
        .snoop_done(snoop_done), .evt_in(evt_in), .state_o(state_o),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
        .snoop_resp_en(snoop_resp_en), .evt_svc(evt_svc), .viol_o(viol_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        stop_req = 0; sleep_req = 0; halt_in = 0; snoop_in = 0;
        intr_txn = 0; snoop_done = 0; evt_in = '0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1; step(); step();
        rst = 0;
    endtask

    initial begin
        do_reset();
        // R9 R10 R6: reset state
        check("R9 state after reset", state_o, 0);
        check("R9 viol after reset", viol_o, 0);
        check("R2 no svc after reset", evt_svc, 0);
        check("R6 core clk in Normal", core_clk_en, 1);
        check("R6 bus clk in Normal", bus_clk_en, 1);
        check("R6 no snoop resp in Normal", snoop_resp_en, 0);

        // R1 R2 R3: every event pattern latched in stopped state
        for (int p = 0; p < 16; p++) begin
            stop_req = 1; step();
            check("R3 Normal to stopped", state_o, 1);
            check("R6 core clk off when stopped", core_clk_en, 0);
            evt_in = p[3:0]; step(); evt_in = 0; step();
            evt_in = p[3:0]; step(); evt_in = 0; step();
            check("R1 no svc while stopped", evt_svc, 0);
            check("R1 still stopped", state_o, 1);
            stop_req = 0; step();
            check("R3 stopped to Normal", state_o, 0);
            check("R2 svc on Normal entry", evt_svc, p);
            step();
            check("R2 svc one shot", evt_svc, 0);
        end

        // R2: rising edge in Normal
        evt_in = 4'b0101; step();
        check("R2 edge pulse in Normal", evt_svc, 4'b0101);
        step();
        check("R2 held level no repeat", evt_svc, 0);
        evt_in = 0; step();

        // R3: stop_req has priority over halt_in
        stop_req = 1; halt_in = 1; step();
        check("R3 stop over halt", state_o, 1);
        stop_req = 0; halt_in = 0; step();
        check("R3 back to Normal", state_o, 0);

        // R8: halted wake for every nonzero pattern
        for (int p = 1; p < 16; p++) begin
            halt_in = 1; step();
            check("R3 Normal to halted", state_o, 2);
            halt_in = 0; step();
            check("R8 stays halted", state_o, 2);
            check("R1 no svc while halted", evt_svc, 0);
            evt_in = p[3:0]; step();
            check("R8 wake to Normal", state_o, 0);
            check("R8 svc on wake", evt_svc, p);
            evt_in = 0; step();
            check("R8 svc one shot", evt_svc, 0);
        end

        // R4: snoop from stopped, events latched in snoop
        stop_req = 1; step();
        snoop_in = 1; step();
        check("R4 stopped to snoop", state_o, 3);
        check("R6 snoop resp enabled", snoop_resp_en, 1);
        snoop_in = 0; evt_in = 4'b0001; step();
        check("R4 waits for done", state_o, 3);
        evt_in = 0; snoop_done = 1; step();
        check("R4 return to stopped", state_o, 1);
        check("R1 no svc after snoop", evt_svc, 0);
        snoop_done = 0; stop_req = 0; step();
        check("R1 snoop-latched svc", evt_svc, 4'b0001);
        step();

        // R4: interrupt transaction from halted
        halt_in = 1; step(); halt_in = 0;
        intr_txn = 1; step();
        check("R4 halted to snoop", state_o, 3);
        intr_txn = 0; step();
        check("R4 return to halted", state_o, 2);
        evt_in = 4'b0010; step();
        check("R8 wake after snoop", evt_svc, 4'b0010);
        evt_in = 0; step();

        // R7: clean sleep entry and exit
        stop_req = 1; step();
        sleep_req = 1; step();
        check("R5 stopped to Sleep", state_o, 4);
        check("R6 core clk off in Sleep", core_clk_en, 0);
        check("R6 bus clk off in Sleep", bus_clk_en, 0);
        step();
        check("R7 no viol quiet Sleep", viol_o, 0);
        sleep_req = 0; step();
        check("R7 Sleep to stopped", state_o, 1);
        stop_req = 0; step();
        check("R7 Normal after Sleep", state_o, 0);
        check("R7 viol still clear", viol_o, 0);

        // R5: sleep request in Normal
        sleep_req = 1; step();
        check("R5 no Sleep from Normal", state_o, 0);
        check("R5 viol from Normal", viol_o, 1);
        sleep_req = 0; step();
        check("R9 viol sticky", viol_o, 1);
        do_reset();
        check("R9 reset clears viol", viol_o, 0);

        // R5: sleep request in halted
        halt_in = 1; step(); halt_in = 0;
        sleep_req = 1; step();
        check("R5 no Sleep from halted", state_o, 2);
        check("R5 viol from halted", viol_o, 1);
        do_reset();

        // R5: sleep request in snoop
        stop_req = 1; step();
        snoop_in = 1; step(); snoop_in = 0;
        sleep_req = 1; step();
        check("R5 no Sleep from snoop", state_o, 3);
        check("R5 viol from snoop", viol_o, 1);
        do_reset();

        // R7: events in Sleep are not latched and are violations
        stop_req = 1; step();
        sleep_req = 1; step();
        evt_in = 4'b0011; step();
        check("R7 event in Sleep viol", viol_o, 1);
        check("R7 still Sleep", state_o, 4);
        evt_in = 0; step();
        sleep_req = 0; step();
        stop_req = 0; step();
        check("R7 Normal after Sleep", state_o, 0);
        check("R7 no latched svc", evt_svc, 0);
        do_reset();

        // R7 R9: snoop in Sleep, then reset straight to Normal
        stop_req = 1; step();
        sleep_req = 1; step();
        snoop_in = 1; step();
        check("R7 snoop in Sleep viol", viol_o, 1);
        check("R7 no snoop state from Sleep", state_o, 4);
        rst = 1; step();
        check("R9 reset from Sleep", state_o, 0);
        check("R9 reset clears viol in Sleep", viol_o, 0);
        clear_inputs(); rst = 0; step();
        check("R9 stays Normal", state_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule